// File: doc/BRIEF.md
# PLL Holdover Controller

This block decides, cycle by cycle, whether a PLL charge pump is allowed to drive the loop filter or must be held in tri-state so that the VCO keeps its last tuning voltage. Two triggers can place the pump in holdover. The first is a manual request made by a falling edge on an active-low sync pin. The second is an automatic request made when the lock detector reports loss of lock. Both triggers are gated by one global holdover enable.

Entry into holdover is immediate. On a manual request, a combinational path raises the tri-state control before any clock edge arrives. Exit is always deferred to the next rising edge of the reference-path PFD event. On that same edge the block emits a one-cycle reset strobe for the feedback B counter, which realigns the R and N divider outputs. The prescaler gets no reset. Each output channel divider has its own sync-ignore bit. A channel whose bit is clear is switched off for as long as the manual holdover is in force.

The block runs in the PFD-domain clock. `ref_pfd_i` is a level in that domain whose rising edge marks a reference PFD event. `sync_ni` is asynchronous and is synchronized inside the block.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: With `hold_en_i` low, `cp_tristate_o` stays low and `b_rst_o` stays low whatever happens on the sync pin and lock inputs. Clearing `hold_en_i` during holdover ends it at the next clock edge without a B-counter strobe.
- R2: Manual holdover is entered only on a high-to-low transition of `sync_ni`. If `sync_ni` is already low when reset is released, no holdover follows.
- R3: On a manual request, `cp_tristate_o` goes high combinationally as soon as `sync_ni` falls, before any clock edge.
- R4: Manual holdover ends on the first clock edge where a rising `ref_pfd_i` is seen after the synchronized `sync_ni` has returned high. A PFD edge while sync is still low does not end it. With no PFD edge, holdover lasts indefinitely.
- R5: `b_rst_o` is high for exactly one clock cycle, starting on the edge that ends holdover.
- R6: With `auto_en_i` high, a low `lock_i` sets `cp_tristate_o` at the next clock edge. With `auto_en_i` low, loss of lock has no effect.
- R7: Automatic holdover ends on the first rising edge of `ref_pfd_i` seen while `lock_i` is high. A `ref_pfd_i` that stays high does not count as a new edge.
- R8: `hold_o` equals `cp_tristate_o` at all times.
- R9: `ch_en_o[i]` is low while manual holdover is pending or active and `ign_sync_i[i]` is 0. In every other case it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PFD-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_pfd_i | input | 1 | Reference-path PFD event level; its rising edge is the exit point |
| sync_ni | input | 1 | Active-low sync pin, asynchronous |
| lock_i | input | 1 | Lock-detect flag, high when locked |
| hold_en_i | input | 1 | Global holdover enable |
| auto_en_i | input | 1 | Enable for holdover on loss of lock |
| ign_sync_i | input | NUM_CH | Per-channel sync-ignore bits |
| cp_tristate_o | output | 1 | Charge-pump tri-state control |
| b_rst_o | output | 1 | One-cycle synchronous reset for the feedback B counter |
| hold_o | output | 1 | Holdover status |
| ch_en_o | output | NUM_CH | Per-channel output enable |

## Verification
Suppose the manual or automatic holdover flag is stuck, or is cleared on the wrong edge. The bench would see `cp_tristate_o` disagree with its expectation on the first sample after the stimulus. The exit checks are sampled exactly one cycle after the PFD edge is driven. The B-counter strobe is checked both on its exit cycle and on the following cycle, so a stretched or misplaced pulse shows within two samples. A broken immediate-entry path shows within the same half cycle as the sync fall, before any clock edge could mask it.

// File: rtl/pll_hold_pkg.sv
package pll_hold_pkg;
  localparam int unsigned DEF_NUM_CH      = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic man;  // manual holdover active
    logic lol;  // loss-of-lock holdover active
  } hold_src_t;
endpackage

// File: rtl/hold_sync_edge.sv
module hold_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  input  logic hold_en_i,
  output logic sync_lvl_o,
  output logic fall_o,
  output logic pend_o
);
  localparam int unsigned LAST = STAGES;

  // reset to low so a pin held low through reset is not an edge
  logic [LAST:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[LAST-1:0], sync_ni};
  end

  assign sync_lvl_o = chain_q[LAST-1];
  assign fall_o     = chain_q[LAST] & ~chain_q[LAST-1];
  // raw fall seen before the edge stage has caught up: immediate entry
  assign pend_o     = hold_en_i & ~sync_ni & chain_q[LAST];

  a_r2_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import pll_hold_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_pfd_i,
  input  logic      lock_i,
  input  logic      hold_en_i,
  input  logic      auto_en_i,
  input  logic      sync_lvl_i,
  input  logic      sync_fall_i,
  output hold_src_t src_o,
  output logic      b_rst_o
);
  logic      pfd_q, pfd_rise;
  hold_src_t src_q, src_d;
  logic      any_q, any_d, b_rst_q, b_rst_d;

  assign pfd_rise = ref_pfd_i & ~pfd_q;
  assign any_q    = src_q.man | src_q.lol;

  always_comb begin
    src_d = src_q;
    if (!hold_en_i) begin
      src_d = '0;
    end else begin
      if (src_q.man) src_d.man = ~(sync_lvl_i & pfd_rise);
      else           src_d.man = sync_fall_i;
      if (src_q.lol) src_d.lol = ~(lock_i & pfd_rise);
      else           src_d.lol = auto_en_i & ~lock_i;
    end
  end

  assign any_d   = src_d.man | src_d.lol;
  assign b_rst_d = hold_en_i & pfd_rise & any_q & ~any_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfd_q   <= 1'b0;
      src_q   <= '0;
      b_rst_q <= 1'b0;
    end else begin
      pfd_q   <= ref_pfd_i;
      src_q   <= src_d;
      b_rst_q <= b_rst_d;
    end
  end

  assign src_o   = src_q;
  assign b_rst_o = b_rst_q;

  a_r1_disabled_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_en_i |=> !any_q);
  a_r4_exit_on_pfd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(any_q) && $past(hold_en_i)) |-> $past(pfd_rise));
  a_r5_brst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rst_q |=> !b_rst_q);
  a_r5_brst_on_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rst_q |-> (!any_q && $past(any_q)));
endmodule

// File: rtl/hold_ch_gate.sv
module hold_ch_gate #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] ign_i,
  input  logic              man_act_i,
  output logic [NUM_CH-1:0] en_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign en_o[g] = ign_i[g] | ~man_act_i;
  end
endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl
  import pll_hold_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_pfd_i,
  input  logic              sync_ni,
  input  logic              lock_i,
  input  logic              hold_en_i,
  input  logic              auto_en_i,
  input  logic [NUM_CH-1:0] ign_sync_i,
  output logic              cp_tristate_o,
  output logic              b_rst_o,
  output logic              hold_o,
  output logic [NUM_CH-1:0] ch_en_o
);
  logic      sync_lvl, sync_fall, sync_pend, man_act;
  hold_src_t src;

  hold_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_ni    (sync_ni),
    .hold_en_i  (hold_en_i),
    .sync_lvl_o (sync_lvl),
    .fall_o     (sync_fall),
    .pend_o     (sync_pend)
  );

  hold_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_pfd_i   (ref_pfd_i),
    .lock_i      (lock_i),
    .hold_en_i   (hold_en_i),
    .auto_en_i   (auto_en_i),
    .sync_lvl_i  (sync_lvl),
    .sync_fall_i (sync_fall),
    .src_o       (src),
    .b_rst_o     (b_rst_o)
  );

  assign man_act       = src.man | sync_pend;
  assign cp_tristate_o = man_act | src.lol;
  assign hold_o        = cp_tristate_o;

  hold_ch_gate #(.NUM_CH(NUM_CH)) u_gate (
    .ign_i     (ign_sync_i),
    .man_act_i (man_act),
    .en_o      (ch_en_o)
  );

  a_r9_ch_on_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_tristate_o |-> (&ch_en_o));
  a_r5_brst_not_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rst_o |-> !src.man && !src.lol);
endmodule

// File: tb/pll_holdover_ctrl_test.sv
module pll_holdover_ctrl_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_ni, ref_pfd, sync_n, lock, hold_en, auto_en;
  logic [NCH-1:0] ign;
  logic tri_o, brst_o, hold_st;
  logic [NCH-1:0] ch_en;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pll_holdover_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_pfd_i(ref_pfd), .sync_ni(sync_n),
    .lock_i(lock), .hold_en_i(hold_en), .auto_en_i(auto_en),
    .ign_sync_i(ign), .cp_tristate_o(tri_o), .b_rst_o(brst_o),
    .hold_o(hold_st), .ch_en_o(ch_en)
  );

  // fields: en, auto_en, lock, pfd, exp_tristate, exp_brst
  localparam logic [5:0] VEC [12] = '{
    6'b111000, 6'b110010, 6'b110110, 6'b111110,
    6'b111010, 6'b111101, 6'b111000, 6'b100000,
    6'b010000, 6'b110010, 6'b010000, 6'b111000
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 0; sync_n = 1; ref_pfd = 0; lock = 1; hold_en = 0; auto_en = 0;
    ign = 4'b0101;
    step(3);
    chk("R8 reset tristate", {7'd0, tri_o}, 8'd0);
    chk("R5 reset brst", {7'd0, brst_o}, 8'd0);
    chk("R8 reset hold", {7'd0, hold_st}, 8'd0);
    chk("R9 reset ch_en", {4'd0, ch_en}, 8'h0f);
    rst_ni = 1;
    step(3);

    // R1 R6 R7 R5 R8: loss-of-lock sequence
    for (int k = 0; k < 12; k++) begin
      hold_en = VEC[k][5]; auto_en = VEC[k][4]; lock = VEC[k][3]; ref_pfd = VEC[k][2];
      step(1);
      chk($sformatf("R6/R7/R1 row %0d tristate", k), {7'd0, tri_o}, {7'd0, VEC[k][1]});
      chk($sformatf("R5 row %0d brst", k), {7'd0, brst_o}, {7'd0, VEC[k][0]});
      chk($sformatf("R8 row %0d hold", k), {7'd0, hold_st}, {7'd0, VEC[k][1]});
    end

    // manual holdover
    auto_en = 0;
    step(1);
    sync_n = 0;
    #1;
    chk("R3 immediate entry", {7'd0, tri_o}, 8'd1);
    chk("R9 channels gated", {4'd0, ch_en}, 8'h05);
    @(negedge clk);
    step(3);
    chk("R2 held after fall", {7'd0, tri_o}, 8'd1);
    ref_pfd = 1; step(1); ref_pfd = 0; step(1);
    chk("R4 pfd with sync low", {7'd0, tri_o}, 8'd1);
    chk("R5 no brst sync low", {7'd0, brst_o}, 8'd0);
    sync_n = 1;
    step(6);
    chk("R4 no pfd stays", {7'd0, tri_o}, 8'd1);
    chk("R9 still gated", {4'd0, ch_en}, 8'h05);
    ref_pfd = 1; step(1);
    chk("R4 exit on pfd", {7'd0, tri_o}, 8'd0);
    chk("R5 brst on exit", {7'd0, brst_o}, 8'd1);
    chk("R9 channels back", {4'd0, ch_en}, 8'h0f);
    ref_pfd = 0; step(1);
    chk("R5 brst one cycle", {7'd0, brst_o}, 8'd0);

    // R1: global enable off blocks manual entry
    hold_en = 0; step(1);
    sync_n = 0;
    #1;
    chk("R1 no entry disabled", {7'd0, tri_o}, 8'd0);
    chk("R9 disabled ch_en", {4'd0, ch_en}, 8'h0f);
    @(negedge clk);
    step(4);
    chk("R1 still idle", {7'd0, tri_o}, 8'd0);
    sync_n = 1; hold_en = 1;
    step(4);

    // R2: sync low through reset is not an edge
    rst_ni = 0; sync_n = 0;
    step(2);
    rst_ni = 1;
    step(5);
    chk("R2 level not edge", {7'd0, tri_o}, 8'd0);
    chk("R5 no brst level", {7'd0, brst_o}, 8'd0);
    sync_n = 1; step(3);
    sync_n = 0;
    #1;
    chk("R3 entry after release", {7'd0, tri_o}, 8'd1);
    @(negedge clk);
    step(2);
    finish_run();
  end
endmodule